// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port Block RAM

This block is a 4096-bit simple dual-port memory. It has one write port and one read port, and each port runs on its own clock. Each port's data width is fixed at elaboration. The choices are 16, 8, 4 or 2 bits per word, and the two ports may use different widths. The address depth grows as the width shrinks. Data always travels on 16-bit buses. In the narrow widths the word sits on fixed, spread-out lanes of the bus, not on the low bits.

All widths view the same 4096-bit store through one bit-index mapping. Element `j` of word `a` in a `W`-bit mode is stored bit `a*W + j`. Data written at one width can therefore be read back at another width. Each port can also be set separately to sample on the falling edge of its clock.

Top module: `aspect_bram`

## Requirements
- R1: The width code of each port (`WR_WIDTH_SEL`, `RD_WIDTH_SEL`) selects the port width. Code 0 gives 16 bits, code 1 gives 8 bits, code 2 gives 4 bits and code 3 gives 2 bits. The two ports are set independently.
- R2: Element `j` of a word sits on a fixed bus lane that depends on the width:
  - 16-bit mode: lane `j`.
  - 8-bit mode: lane `2j`, which gives lanes 0,2,4,...,14.
  - 4-bit mode: lane `4j+1`, which gives lanes 1,5,9,13.
  - 2-bit mode: lane `8j+3`, which gives lanes 3 and 11.
- R3: The number of address bits used depends on the width code: 8 bits for code 0, 9 for code 1, 10 for code 2 and 11 for code 3. Address bits above those are ignored.
- R4: Element `j` of the word at used address `a` in a `W`-bit mode maps to store bit `a*W + j`. The write port and the read port use the same mapping.
- R5: In 16-bit write mode, a `wr_mask` bit of 1 leaves the matching stored bit unchanged. In the narrow write modes, `wr_mask` is ignored.
- R6: A read takes effect on an active read-clock edge when `rd_en` and `rd_clk_en` are both 1. `rd_data` then shows the word at the address presented at that edge. Otherwise `rd_data` keeps its value.
- R7: `rd_data` lanes that the read width does not use are 0.
- R8: The store changes only on an active write-clock edge with `wr_en` and `wr_clk_en` both 1.
- R9: `WR_CLK_INV` moves the active write edge to the falling edge of `wr_clk`. `RD_CLK_INV` does the same for `rd_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_clk_en | input | 1 | Write clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 11 | Write word address |
| wr_data | input | 16 | Write data bus (lanes per R2) |
| wr_mask | input | 16 | Per-bit write protect, 16-bit mode only |
| rd_clk | input | 1 | Read clock |
| rd_clk_en | input | 1 | Read clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 11 | Read word address |
| rd_data | output | 16 | Registered read data bus |

## Verification
The hardest case to reach is the cross-width bit mapping. A mismatch shows up only when the same stored bits are written at one width and read back at another. The bench drives three instances with the same stimulus. Their write/read width pairs are 16/4, 2/8 and 8/16, and one of them uses an inverted read clock. The bench first fills every address, using 11-bit addresses whose high bits the wide modes must ignore. It then sweeps the reads and follows with random masked writes and reads. The falling-edge read is caught by an extra sample between the two clock edges.

// File: rtl/abram_pkg.sv
package abram_pkg;
    localparam int BUS_W      = 16;
    localparam int ADDR_W     = 11;
    localparam int TOTAL_BITS = 4096;
    localparam int ROWS       = TOTAL_BITS / BUS_W;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int LANE_IW    = $clog2(BUS_W);

    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [BUS_W-1:0]  we;
        logic [BUS_W-1:0]  bits;
    } wr_req_t;

    function automatic int lane_of(logic [1:0] mode, int j);
        int stride;
        stride = 1 << mode;
        if (mode == 2'd0) return j;
        return j * stride + (stride / 2) - 1;
    endfunction

    function automatic logic [BUS_W-1:0] used_lanes(logic [1:0] mode);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int j = 0; j < (BUS_W >> mode); j++) m[LANE_IW'(lane_of(mode, j))] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/abram_wr_map.sv
module abram_wr_map
    import abram_pkg::*;
#(
    parameter logic [1:0] MODE = 2'd0
) (
    input  logic              active_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  data_i,
    input  logic [BUS_W-1:0]  mask_i,
    output wr_req_t           req_o
);
    localparam int W        = BUS_W >> MODE;
    localparam int PER_ROW  = 1 << MODE;
    localparam int USED_AW  = ROW_AW + int'(MODE);

    int a_used;
    int off;

    always_comb begin
        a_used = int'(addr_i) & ((1 << USED_AW) - 1);
        off    = (a_used & (PER_ROW - 1)) * W;
        req_o.row  = ROW_AW'(a_used >> MODE);
        req_o.we   = '0;
        req_o.bits = '0;
        for (int c = 0; c < BUS_W; c++) begin
            if (c >= off && c < off + W) begin
                req_o.bits[c] = data_i[LANE_IW'(lane_of(MODE, c - off))];
                req_o.we[c]   = active_i & ((MODE != 2'd0) | ~mask_i[c]);
            end
        end
    end
endmodule

// File: rtl/abram_rd_map.sv
module abram_rd_map
    import abram_pkg::*;
#(
    parameter logic [1:0] MODE = 2'd0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  word_i,
    output logic [ROW_AW-1:0] row_o,
    output logic [BUS_W-1:0]  lanes_o
);
    localparam int W        = BUS_W >> MODE;
    localparam int PER_ROW  = 1 << MODE;
    localparam int USED_AW  = ROW_AW + int'(MODE);

    int a_used;
    int off;

    always_comb begin
        a_used  = int'(addr_i) & ((1 << USED_AW) - 1);
        off     = (a_used & (PER_ROW - 1)) * W;
        row_o   = ROW_AW'(a_used >> MODE);
        lanes_o = '0;
        for (int j = 0; j < W; j++)
            lanes_o[LANE_IW'(lane_of(MODE, j))] = word_i[LANE_IW'(off + j)];
    end
endmodule

// File: rtl/abram_store.sv
module abram_store
    import abram_pkg::*;
(
    input  logic              wclk_i,
    input  wr_req_t           req_i,
    input  logic [ROW_AW-1:0] rd_row_i,
    output logic [BUS_W-1:0]  rd_word_o
);
    logic [BUS_W-1:0] mem_q [ROWS];
    logic [BUS_W-1:0] row_d;

    always_comb begin
        row_d = (mem_q[req_i.row] & ~req_i.we) | (req_i.bits & req_i.we);
    end

    always_ff @(posedge wclk_i) begin
        if (|req_i.we) mem_q[req_i.row] <= row_d;
    end

    assign rd_word_o = mem_q[rd_row_i];
endmodule

// File: rtl/aspect_bram.sv
module aspect_bram
    import abram_pkg::*;
#(
    parameter logic [1:0] WR_WIDTH_SEL = 2'd0,
    parameter logic [1:0] RD_WIDTH_SEL = 2'd0,
    parameter bit         WR_CLK_INV   = 1'b0,
    parameter bit         RD_CLK_INV   = 1'b0
) (
    input  logic              wr_clk,
    input  logic              wr_clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [BUS_W-1:0]  wr_mask,
    input  logic              rd_clk,
    input  logic              rd_clk_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int WR_W = BUS_W >> WR_WIDTH_SEL;
    localparam logic [BUS_W-1:0] RD_LANES = used_lanes(RD_WIDTH_SEL);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             seen;
    } rd_state_t;

    logic             wclk_int, rclk_int;
    logic             wr_fire, rd_fire;
    wr_req_t          wr_req;
    logic [ROW_AW-1:0] rd_row;
    logic [BUS_W-1:0] rd_word, rd_lanes;
    rd_state_t        rd_d, rd_q;

    assign wclk_int = WR_CLK_INV ? ~wr_clk : wr_clk;   // R9
    assign rclk_int = RD_CLK_INV ? ~rd_clk : rd_clk;
    assign wr_fire  = wr_en & wr_clk_en;
    assign rd_fire  = rd_en & rd_clk_en;

    abram_wr_map #(.MODE(WR_WIDTH_SEL)) u_wmap (
        .active_i(wr_fire), .addr_i(wr_addr), .data_i(wr_data),
        .mask_i(wr_mask), .req_o(wr_req)
    );

    abram_store u_store (
        .wclk_i(wclk_int), .req_i(wr_req), .rd_row_i(rd_row), .rd_word_o(rd_word)
    );

    abram_rd_map #(.MODE(RD_WIDTH_SEL)) u_rmap (
        .addr_i(rd_addr), .word_i(rd_word), .row_o(rd_row), .lanes_o(rd_lanes)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_fire) begin
            rd_d.rdata = rd_lanes;
            rd_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge rclk_int) begin
        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;

    // checks on the read side
    logic rd_ok_q = 1'b0;
    always_ff @(posedge rclk_int) rd_ok_q <= (rd_q.seen === 1'b1);

    p_hold_r6: assert property (@(posedge rclk_int) disable iff (!rd_ok_q)
        !rd_fire |=> $stable(rd_data));

    p_unused_zero_r7: assert property (@(posedge rclk_int) disable iff (!rd_ok_q)
        (rd_data & ~RD_LANES) == '0);

    // checks on the write side
    logic wr_ok_q = 1'b0;
    always_ff @(posedge wclk_int) wr_ok_q <= 1'b1;

    p_idle_r8: assert property (@(posedge wclk_int) disable iff (!wr_ok_q)
        !wr_fire |-> wr_req.we == '0);

    generate
        if (WR_WIDTH_SEL == 2'd0) begin : g_wide
            p_mask_r5: assert property (@(posedge wclk_int) disable iff (!wr_ok_q)
                wr_fire |-> (wr_req.we & wr_mask) == '0);
        end else begin : g_narrow
            p_width_r4: assert property (@(posedge wclk_int) disable iff (!wr_ok_q)
                wr_fire |-> $countones(wr_req.we) == WR_W);
        end
    endgenerate
endmodule

// File: tb/aspect_bram_test.sv
module aspect_bram_test;
    localparam int NI = 3;
    localparam int WM [NI] = '{0, 3, 1};
    localparam int RM [NI] = '{2, 1, 0};

    logic        clk = 1'b0;
    logic        wr_clk_en = 0, wr_en = 0, rd_clk_en = 0, rd_en = 0;
    logic [10:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, wr_mask = '0;
    logic [15:0] rdata [NI];

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;
    bit  refm [NI][4096];
    logic [15:0] expd [NI];
    bit  live [NI];

    always #4 clk = ~clk;   // 125 MHz

    aspect_bram #(.WR_WIDTH_SEL(2'd0), .RD_WIDTH_SEL(2'd2), .WR_CLK_INV(1'b0), .RD_CLK_INV(1'b0)) uut (
        .wr_clk(clk), .wr_clk_en(wr_clk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_clk(clk), .rd_clk_en(rd_clk_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rdata[0]));
    aspect_bram #(.WR_WIDTH_SEL(2'd3), .RD_WIDTH_SEL(2'd1), .WR_CLK_INV(1'b1), .RD_CLK_INV(1'b0)) uut_b (
        .wr_clk(clk), .wr_clk_en(wr_clk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_clk(clk), .rd_clk_en(rd_clk_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rdata[1]));
    aspect_bram #(.WR_WIDTH_SEL(2'd1), .RD_WIDTH_SEL(2'd0), .WR_CLK_INV(1'b0), .RD_CLK_INV(1'b1)) uut_c (
        .wr_clk(clk), .wr_clk_en(wr_clk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_clk(clk), .rd_clk_en(rd_clk_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rdata[2]));

    function automatic int lane(int m, int j);
        if (m == 0) return j;
        if (m == 1) return 2 * j;
        if (m == 2) return 4 * j + 1;
        return 8 * j + 3;
    endfunction

    function automatic logic [15:0] lanemask(int m);
        logic [15:0] v = '0;
        for (int j = 0; j < (16 >> m); j++) v[lane(m, j)] = 1'b1;
        return v;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, int k);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d actual=%h expected=%h", tag, k, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic model_update();
        for (int k = 0; k < NI; k++) begin
            if (wr_en && wr_clk_en) begin
                int w = 16 >> WM[k];
                int a = int'(wr_addr) & ((1 << (8 + WM[k])) - 1);
                for (int j = 0; j < w; j++)
                    if (WM[k] != 0 || !wr_mask[j]) refm[k][a * w + j] = wr_data[lane(WM[k], j)];
            end
            if (rd_en && rd_clk_en) begin
                int w = 16 >> RM[k];
                int a = int'(rd_addr) & ((1 << (8 + RM[k])) - 1);
                expd[k] = '0;
                for (int j = 0; j < w; j++) expd[k][lane(RM[k], j)] = refm[k][a * w + j];
                live[k] = 1;
            end
        end
    endtask

    task automatic step(bit we, bit wce, logic [10:0] wa, logic [15:0] wd, logic [15:0] wmk,
                        bit re, bit rce, logic [10:0] ra, string tag);
        bit reads;
        @(posedge clk);
        #2;
        wr_en = we; wr_clk_en = wce; wr_addr = wa; wr_data = wd; wr_mask = wmk;
        rd_en = re; rd_clk_en = rce; rd_addr = ra;
        reads = re && rce;
        model_update();
        #4;   // falling edge passed, rising edge not yet
        if (reads && live[2]) check("R9 falling-edge read", rdata[2], expd[2], 2);
        #3;
        for (int k = 0; k < NI; k++) if (live[k]) begin
            check(tag, rdata[k], expd[k], k);
            check("R7 unused lanes", rdata[k] & ~lanemask(RM[k]), 16'h0, k);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NI; k++) live[k] = 0;
        // fill every address; high address bits vary (R3)
        for (int i = 0; i < 2048; i++)
            step(1, 1, 11'(i), 16'($urandom), 16'h0, 0, 1, '0, "fill");
        // first read defines rd_data
        step(0, 1, '0, '0, '0, 1, 1, 11'd0, "R6 first read");
        // sweep across all addresses with cross-width mapping
        for (int i = 0; i < 2048; i++)
            step(0, 0, '0, '0, '0, 1, 1, 11'(i), "R1/R2/R3/R4 sweep");
        // hold when either enable low
        step(0, 0, '0, '0, '0, 0, 1, 11'd77, "R6 hold rd_en=0");
        step(0, 0, '0, '0, '0, 1, 0, 11'd91, "R6 hold rd_clk_en=0");
        // gated writes must not change the store
        step(1, 0, 11'd5, 16'hFFFF, 16'h0, 0, 0, '0, "R8 gated");
        step(0, 1, 11'd5, 16'h0000, 16'h0, 0, 0, '0, "R8 gated");
        step(0, 0, '0, '0, '0, 1, 1, 11'd5, "R8 readback");
        // random mixed traffic with masks
        for (int i = 0; i < 3000; i++) begin
            if (i % 2 == 0)
                step(($urandom % 4) != 0, ($urandom % 4) != 0, 11'($urandom), 16'($urandom),
                     16'($urandom), 0, 1, '0, "R5 write");
            else
                step(0, 0, '0, '0, '0, ($urandom % 4) != 0, ($urandom % 4) != 0, 11'($urandom),
                     "R5/R6/R8 read");
        end
        finish_run();
    end
endmodule